// File: doc/BRIEF.md
# Windowed Edge-Frequency Meter

This block measures how often rising edges occur on an already synchronized incremental track input. It opens a measurement on a rising edge and records two things: the running edge count and a timestamp taken from a free-running 100 ns tick. It then lets a programmable window elapse. The measurement closes on the first rising edge after the window. The result is the number of edge intervals divided by the time actually measured between the opening and closing edges, expressed in hertz. The nominal window length is not used in the division.

If no closing edge arrives within a programmable wait after the window, the measurement gives up. The frequency output is then forced to zero. A gate-block input freezes edge counting and abandons any open measurement. A restart pulse aborts the open measurement, and the next rising edge starts a fresh one. Between completions the last frequency value is held.

The quotient comes from a 32-step restoring divider. A busy flag is high from the closing edge until the new value lands.

Top module: `edge_rate_meter`

## Requirements
- R1: After reset, `freq_hz` is 0, `freq_valid` is 0 and `busy` is 0, and the block waits for a rising edge.
- R2: A measurement opens only on a rising edge of `trk_in` (low in one cycle, high in the next) seen while `gate_blk` and `restart` are both low. A level held high opens nothing.
- R3: After opening, the block waits until the elapsed time reaches the window (`win_us` microseconds, 10 ticks of 100 ns per microsecond). It then closes on the next rising edge, so edges arriving before the window has elapsed never close it.
- R4: On closing, the result is floor(N x 10,000,000 / T). N is the number of rising edges from the opening edge up to the closing edge, and T is the number of 100 ns ticks between those two edges.
- R5: A `win_us` value of 0 is treated as the minimum window of 1 µs.
- R6: If no rising edge arrives within the wait time after the window, `freq_hz` becomes 0, `freq_valid` becomes 1, and the block waits for a new opening edge.
- R7: The wait time is `tmo_us` microseconds, limited to at most TMO_MAX_US (1,600,000 by default) and at least 1.
- R8: While `gate_blk` is high, edges are not counted and any open measurement is abandoned without a result or a timeout. `freq_hz` keeps its value.
- R9: A `restart` pulse abandons the open measurement without changing the outputs. The next rising edge after it opens a new measurement.
- R10: `busy` goes high in the cycle after the closing edge is sampled and stays high for exactly 34 cycles. The new `freq_hz` appears in the same cycle that `busy` falls.
- R11: `freq_hz` changes only when a result or a timeout lands. Once set, `freq_valid` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_in | input | 1 | Synchronized track signal |
| gate_blk | input | 1 | High blocks counting and measurement |
| restart | input | 1 | One-cycle pulse that aborts the open measurement |
| win_us | input | 32 | Window length in microseconds |
| tmo_us | input | 32 | Post-window wait limit in microseconds |
| freq_hz | output | Q_W (32) | Last measured frequency in hertz |
| freq_valid | output | 1 | A result or a timeout has landed since reset |
| busy | output | 1 | A closed measurement is being divided |

## Verification
A stuck or mis-sequenced controller shows at the ports within one edge period. It shows as `busy` rising on the wrong edge of a counted pulse train, or as `busy` not rising at all. A wrong capture of count or time shows up as a wrong quotient at the fall of `busy`. This happens 34 cycles after the closing edge, and it shows across a sweep of edge periods for which the exact answer is 10,000,000 divided by the period in ticks. A broken abort or timeout path shows up within one window-plus-wait interval, as `freq_hz` dropping to zero when it should hold, or holding when it should drop.

// File: rtl/erm_pkg.sv
package erm_pkg;

    // 100 ns ticks in one microsecond
    localparam int TICKS_PER_US = 10;
    // hertz per (edges per tick)
    localparam longint HZ_SCALE = 64'd10_000_000;
    // upper bound on the window so the tick count stays inside 32 bits
    localparam int WIN_MAX_US = 400_000_000;

    typedef enum logic [2:0] {
        ST_ARM  = 3'd0,
        ST_WIN  = 3'd1,
        ST_WAIT = 3'd2,
        ST_LOAD = 3'd3,
        ST_DIV  = 3'd4
    } erm_state_e;

    // clamp a microsecond setting into [lo, hi] and convert to ticks
    function automatic logic [31:0] us_to_ticks(input logic [31:0] us,
                                                input logic [31:0] lo,
                                                input logic [31:0] hi);
        logic [31:0] v;
        v = (us < lo) ? lo : ((us > hi) ? hi : us);
        return v * 32'(TICKS_PER_US);
    endfunction

endpackage

// File: rtl/erm_timebase.sv
module erm_timebase #(
    parameter int PRESCALE = 25,
    parameter int TS_W     = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic            tick,
    output logic [TS_W-1:0] ts
);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst)               pre_q <= '0;
                else if (pre_q == LAST) pre_q <= '0;
                else                   pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       ts <= '0;
        else if (tick) ts <= ts + 1'b1;
    end

    // R4
    ts_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (ts == $past(ts) + 1'b1));

endmodule

// File: rtl/erm_edge_count.sv
module erm_edge_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trk_in,
    input  logic             gate_blk,
    output logic             rise,
    output logic [CNT_W-1:0] cnt
);

    logic trk_q;

    always_ff @(posedge clk) begin
        if (rst) trk_q <= 1'b0;
        else     trk_q <= trk_in;
    end

    assign rise = trk_in & ~trk_q & ~gate_blk;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (rise) cnt <= cnt + 1'b1;
    end

    // R8
    cnt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        gate_blk |=> $stable(cnt));

endmodule

// File: rtl/erm_divider.sv
module erm_divider #(
    parameter int Q_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2*Q_W-1:0] num,
    input  logic [Q_W-1:0]   den,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quot
);

    localparam int CW = $clog2(Q_W);
    localparam logic [CW-1:0] LAST = CW'(Q_W - 1);

    logic [Q_W:0]   rem_q;
    logic [Q_W-1:0] low_q;
    logic [Q_W-1:0] den_q;
    logic [CW-1:0]  step_q;
    logic [Q_W:0]   trial;
    logic           take;
    logic [Q_W:0]   rem_nx;

    always_comb begin
        trial  = {rem_q[Q_W-1:0], low_q[Q_W-1]};
        take   = (trial >= {1'b0, den_q});
        rem_nx = take ? (trial - {1'b0, den_q}) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            low_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            quot   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= {1'b0, num[2*Q_W-1:Q_W]};
                low_q  <= num[Q_W-1:0];
                den_q  <= den;
                step_q <= '0;
                quot   <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                rem_q  <= rem_nx;
                low_q  <= {low_q[Q_W-2:0], 1'b0};
                quot   <= {quot[Q_W-2:0], take};
                step_q <= step_q + 1'b1;
                if (step_q == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || !busy) run_q <= '0;
        else              run_q <= run_q + 1'b1;
    end

    // R10
    div_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < (CW+1)'(Q_W)));

    // R10
    div_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4
    div_den_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (den != '0));

endmodule

// File: rtl/erm_ctrl.sv
module erm_ctrl
    import erm_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TS_W       = 32,
    parameter int Q_W        = 32,
    parameter int WIN_MIN_US = 1,
    parameter int TMO_MAX_US = 1_600_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             gate_blk,
    input  logic             restart,
    input  logic [CNT_W-1:0] cnt,
    input  logic [TS_W-1:0]  ts,
    input  logic [31:0]      win_us,
    input  logic [31:0]      tmo_us,
    input  logic             div_done,
    input  logic [Q_W-1:0]   div_quot,
    output logic             div_start,
    output logic [2*Q_W-1:0] div_num,
    output logic [Q_W-1:0]   div_den,
    output logic [Q_W-1:0]   freq_hz,
    output logic             freq_valid,
    output logic             busy
);

    erm_state_e st_q, st_d;

    logic [CNT_W-1:0] cnt0_q, cnt1_q;
    logic [TS_W-1:0]  ts0_q, ts1_q, mark_q;
    logic [TS_W-1:0]  elapsed, idle_t;
    logic [31:0]      win_ticks, tmo_ticks;
    logic             abort, tmo_hit, result_in;

    assign win_ticks = us_to_ticks(win_us, 32'(WIN_MIN_US), 32'(WIN_MAX_US));
    assign tmo_ticks = us_to_ticks(tmo_us, 32'd1, 32'(TMO_MAX_US));
    assign elapsed   = ts - ts0_q;
    assign idle_t    = ts - mark_q;
    assign abort     = restart | gate_blk;
    assign tmo_hit   = (st_q == ST_WAIT) && !abort && !rise &&
                       (32'(idle_t) >= tmo_ticks);
    assign result_in = (st_q == ST_DIV) && div_done;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARM:  if (rise && !restart) st_d = ST_WIN;
            ST_WIN:  if (abort) st_d = ST_ARM;
                     else if (32'(elapsed) >= win_ticks) st_d = ST_WAIT;
            ST_WAIT: if (abort) st_d = ST_ARM;
                     else if (rise) st_d = ST_LOAD;
                     else if (32'(idle_t) >= tmo_ticks) st_d = ST_ARM;
            ST_LOAD: st_d = ST_DIV;
            ST_DIV:  if (div_done) st_d = ST_ARM;
            default: st_d = ST_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_ARM;
            cnt0_q     <= '0;
            cnt1_q     <= '0;
            ts0_q      <= '0;
            ts1_q      <= '0;
            mark_q     <= '0;
            freq_hz    <= '0;
            freq_valid <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_ARM && st_d == ST_WIN) begin
                cnt0_q <= cnt;
                ts0_q  <= ts;
            end
            if (st_q == ST_WIN && st_d == ST_WAIT) mark_q <= ts;
            if (st_q == ST_WAIT && st_d == ST_LOAD) begin
                cnt1_q <= cnt;
                ts1_q  <= ts;
            end
            if (result_in) begin
                freq_hz    <= div_quot;
                freq_valid <= 1'b1;
            end
            if (tmo_hit) begin
                freq_hz    <= '0;
                freq_valid <= 1'b1;
            end
        end
    end

    always_comb begin
        div_start = (st_q == ST_LOAD);
        div_num   = (2*Q_W)'(cnt1_q - cnt0_q) * (2*Q_W)'(HZ_SCALE);
        div_den   = Q_W'(ts1_q - ts0_q);
        busy      = (st_q == ST_LOAD) || (st_q == ST_DIV);
    end

    // R8
    // R9
    load_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOAD) |-> (!$past(gate_blk) && !$past(restart)));

    // R3
    win_span_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOAD && $stable(win_us)) |-> (32'(ts1_q - ts0_q) >= win_ticks));

    // R6
    tmo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> (freq_hz == '0 && freq_valid));

    // R11
    valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
        freq_valid |=> freq_valid);

    // R11
    freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!div_done && !tmo_hit) |=> $stable(freq_hz));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        result_in |=> !busy);

endmodule

// File: rtl/edge_rate_meter.sv
module edge_rate_meter #(
    parameter int PRESCALE   = 25,
    parameter int CNT_W      = 32,
    parameter int TS_W       = 32,
    parameter int Q_W        = 32,
    parameter int WIN_MIN_US = 1,
    parameter int TMO_MAX_US = 1_600_000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trk_in,
    input  logic           gate_blk,
    input  logic           restart,
    input  logic [31:0]    win_us,
    input  logic [31:0]    tmo_us,
    output logic [Q_W-1:0] freq_hz,
    output logic           freq_valid,
    output logic           busy
);

    logic             tick;
    logic [TS_W-1:0]  ts;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic             div_start, div_busy, div_done;
    logic [2*Q_W-1:0] div_num;
    logic [Q_W-1:0]   div_den, div_quot;

    erm_timebase #(.PRESCALE(PRESCALE), .TS_W(TS_W)) u_tb (
        .clk(clk), .rst(rst), .tick(tick), .ts(ts)
    );

    erm_edge_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .trk_in(trk_in), .gate_blk(gate_blk),
        .rise(rise), .cnt(cnt)
    );

    erm_ctrl #(
        .CNT_W(CNT_W), .TS_W(TS_W), .Q_W(Q_W),
        .WIN_MIN_US(WIN_MIN_US), .TMO_MAX_US(TMO_MAX_US)
    ) u_ctrl (
        .clk(clk), .rst(rst), .rise(rise), .gate_blk(gate_blk),
        .restart(restart), .cnt(cnt), .ts(ts),
        .win_us(win_us), .tmo_us(tmo_us),
        .div_done(div_done), .div_quot(div_quot),
        .div_start(div_start), .div_num(div_num), .div_den(div_den),
        .freq_hz(freq_hz), .freq_valid(freq_valid), .busy(busy)
    );

    erm_divider #(.Q_W(Q_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .num(div_num),
        .den(div_den), .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    // R10
    div_cover_chk: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> busy);

endmodule

// File: tb/sim_edge_rate_meter.sv
module sim_edge_rate_meter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trk_in = 1'b0;
    logic        gate_blk = 1'b0;
    logic        restart = 1'b0;
    logic [31:0] win_us = 32'd1;
    logic [31:0] tmo_us = 32'd20;
    logic [31:0] freq_hz;
    logic        freq_valid;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int rises = 0;
    int run_len = 0;
    int last_len = 0;
    int cycles = 0;
    logic pb = 1'b0;

    always #2 clk = ~clk;

    edge_rate_meter #(.PRESCALE(2), .TMO_MAX_US(20)) u0 (
        .clk(clk), .rst(rst), .trk_in(trk_in), .gate_blk(gate_blk),
        .restart(restart), .win_us(win_us), .tmo_us(tmo_us),
        .freq_hz(freq_hz), .freq_valid(freq_valid), .busy(busy)
    );

    // observe busy away from the active edge
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (busy && !pb) rises = rises + 1;
        if (busy) run_len = run_len + 1;
        else if (pb) begin
            last_len = run_len;
            run_len = 0;
        end
        pb = busy;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    // n rising edges, each period 2*half clocks (half ticks at prescale 2)
    task automatic edges(input int half, input int n);
        for (int i = 0; i < n; i++) begin
            trk_in = 1'b1;
            wait_cyc(half);
            trk_in = 1'b0;
            wait_cyc(half);
        end
    endtask

    task automatic measure(input int half, input int w);
        win_us = w;
        pulse_restart();
        edges(half, (10 * w) / half + 3);
        pulse_restart();
        wait_cyc(40);
    endtask

    // count edges driven until busy rises
    task automatic edges_to_close(input int w, output int n);
        int base;
        win_us = w;
        pulse_restart();
        base = rises;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            if (rises == base) begin
                edges(6, 1);
                n++;
            end
        end
        pulse_restart();
        wait_cyc(40);
    endtask

    initial begin
        int n;
        longint keep;
        tmo_us = 32'd20;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // R1
        check(freq_hz == 0, "R1 freq", freq_hz, 0);
        check(freq_valid == 0, "R1 valid", freq_valid, 0);
        check(busy == 0, "R1 busy", busy, 0);

        // R3: edge period 6 ticks, window 1 us closes on 3rd edge, 2 us on 5th
        edges_to_close(1, n);
        check(n == 3, "R3 window 1us edges", n, 3);
        edges_to_close(2, n);
        check(n == 5, "R3 window 2us edges", n, 5);
        // R5: zero window acts as 1 us
        edges_to_close(0, n);
        check(n == 3, "R5 zero window edges", n, 3);

        // R4 sweep: exact answer is 1e7 / half for every window
        for (int w = 1; w <= 3; w++) begin
            for (int h = 1; h <= 20; h++) begin
                measure(h, w);
                check(longint'(freq_hz) == 64'd10_000_000 / h, "R4 freq", freq_hz,
                      64'd10_000_000 / h);
                // R10
                check(last_len == 34, "R10 busy length", last_len, 34);
            end
        end
        check(freq_valid == 1, "R11 valid set", freq_valid, 1);

        // R2: a held level opens nothing; a later rise does
        win_us = 1; tmo_us = 5;
        measure(4, 1);
        keep = freq_hz;
        trk_in = 1'b1;
        pulse_restart();
        wait_cyc(300);
        check(longint'(freq_hz) == keep, "R2 level no open", freq_hz, keep);
        trk_in = 1'b0;
        wait_cyc(2);
        edges(5, 1);
        wait_cyc(150);
        check(freq_hz == 0, "R2 rise opens then R6 timeout", freq_hz, 0);

        // R6: timeout at window 20 clk + wait 100 clk after the opening edge
        measure(4, 1);
        keep = freq_hz;
        edges(5, 1);
        wait_cyc(90);
        check(longint'(freq_hz) == keep, "R11 hold before timeout", freq_hz, keep);
        wait_cyc(40);
        check(freq_hz == 0, "R6 timeout zero", freq_hz, 0);
        check(freq_valid == 1, "R6 timeout valid", freq_valid, 1);

        // R7: 1000 us limited to 20 us -> 420 clk after the opening edge
        tmo_us = 1000;
        measure(4, 1);
        keep = freq_hz;
        edges(5, 1);
        wait_cyc(370);
        check(longint'(freq_hz) == keep, "R7 before clamp", freq_hz, keep);
        wait_cyc(80);
        check(freq_hz == 0, "R7 clamped timeout", freq_hz, 0);

        // R8: gated edges produce nothing; gate aborts an open measurement
        tmo_us = 5;
        measure(4, 1);
        keep = freq_hz;
        n = rises;
        gate_blk = 1'b1;
        pulse_restart();
        edges(3, 40);
        wait_cyc(40);
        check(rises == n, "R8 no busy while gated", rises, n);
        check(longint'(freq_hz) == keep, "R8 freq held", freq_hz, keep);
        gate_blk = 1'b0;
        wait_cyc(2);
        edges(5, 1);
        gate_blk = 1'b1;
        wait_cyc(200);
        check(longint'(freq_hz) == keep, "R8 abort no timeout", freq_hz, keep);
        gate_blk = 1'b0;

        // R9: restart abandons, next rise opens fresh
        wait_cyc(2);
        edges(5, 1);
        pulse_restart();
        wait_cyc(200);
        check(longint'(freq_hz) == keep, "R9 restart no timeout", freq_hz, keep);
        measure(7, 1);
        check(longint'(freq_hz) == 64'd10_000_000 / 7, "R9 fresh measurement", freq_hz,
              64'd10_000_000 / 7);
        check(freq_valid == 1, "R11 valid kept", freq_valid, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule